// File: doc/BRIEF.md
# Hardware Return Address Stack

This block holds the return addresses of a processor core in a stack of its own, kept apart from program and data memory. It has 31 entries of 21 bits and a 5-bit pointer. The pointer value zero is the empty state, and no entry sits behind it.

When a call, a relative call or an interrupt acknowledge occurs, the core raises `push_req` with the address of the next instruction. The block first moves the pointer up by one. It then writes the address into the entry the pointer now selects. When a return, a return with literal or a return from interrupt occurs, the core raises `pop_req`. In that cycle it takes the entry at the current pointer from `pop_addr`, and the pointer then moves down by one.

Software reaches the block through a small byte-wide register port. One register holds the pointer and the status flags. Three more registers hold the top entry, one byte each: low, high and upper.

An occupancy state machine has three states:

- `STK_EMPTY`: the pointer is zero.
- `STK_PARTIAL`: the pointer is between 1 and 30.
- `STK_FULL`: the pointer is 31.

Its named transitions are:

- `fill`: a push from `STK_EMPTY` goes to `STK_PARTIAL`.
- `grow`: a push in `STK_PARTIAL` stays there, or goes to `STK_FULL` when the pointer reaches 31.
- `shrink`: a pop in `STK_PARTIAL` stays there, or goes to `STK_EMPTY` when the pointer reaches zero.
- `drain`: a pop from `STK_FULL` goes to `STK_PARTIAL`.
- `overrun`: a push in `STK_FULL` stays in `STK_FULL` and sets the overflow flag.
- `underrun`: a pop in `STK_EMPTY` stays in `STK_EMPTY` and sets the underflow flag.
- `relocate`: a pointer write from any state goes to the state that the written value selects.

Top module: `retstack`

## Requirements
- R1: After reset the pointer is zero and both sticky flags are clear. The status register (address 0) reads 0x00, `pop_addr` is zero, and the three top registers read zero.
- R2: A push while the pointer is below 31 adds one to the pointer. It then stores `push_addr` at the new pointer, so that `pop_addr` and the top registers show that value after the clock edge.
- R3: While `pop_req` is high, `pop_addr` carries the entry at the current pointer. A pop at a nonzero pointer subtracts one from the pointer at the clock edge.
- R4: While the pointer is zero, `pop_addr` and the three top registers (addresses 1, 2 and 3) read zero. Register writes to addresses 1 to 3 are ignored.
- R5: Status bit 5 (full) is 1 exactly when the pointer equals 31. This bit is read-only.
- R6: A push at pointer 31 sets status bit 7 (overflow). It leaves the pointer at 31 and leaves entry 31 unchanged.
- R7: A pop at pointer zero sets status bit 6 (underflow). `pop_addr` is zero during that pop, and the pointer stays zero.
- R8: The overflow and underflow flags hold their value until a write to address 0 loads them from write bits 7 and 6.
- R9: A write to address 0 loads the pointer from write bits 4:0. Status bits 4:0 read back the pointer.
- R10: Address 1 reads and writes entry bits 7:0 of the entry at the pointer, and address 2 handles bits 15:8. Address 3 handles bits 20:16 in bits 4:0, and its bits 7:5 read zero. Each write changes only its own field.
- R11: When push and pop are requested in the same cycle, only the push takes effect. A register write in a cycle that has a push or a pop is dropped.
- R12: Values come back from pops in the reverse of the order in which they were pushed, across the full depth of 31 entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_req | input | 1 | Push request from a call, relative call or interrupt acknowledge |
| push_addr | input | 21 | Return address to store on a push |
| pop_req | input | 1 | Pop request from a return, return with literal or return from interrupt |
| pop_addr | output | 21 | Entry at the current pointer, or zero when the stack is empty |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status/pointer, 1 low, 2 high, 3 upper |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |

## Verification
The first pattern is a rising fill of all 31 entries with arithmetic address patterns. It is followed by a full drain, which separates correct last-in-first-out ordering from an off-by-one in the pre-increment or the post-decrement.

A sweep writes every pointer value from 0 to 31 and reads the status register back. This separates the full flag and the empty-state decode from the flag bits they sit next to.

Single-byte writes to a mid-stack entry show whether each byte lane is isolated. Pushes at 31 and pops at 0 show whether the pointer stays put while the sticky flags latch. Requests made in the same cycle show the priority between push, pop and register writes.

// File: rtl/retstack_pkg.sv
package retstack_pkg;

    typedef enum logic [1:0] {
        STK_EMPTY   = 2'd0,
        STK_PARTIAL = 2'd1,
        STK_FULL    = 2'd2
    } stk_state_e;

    typedef enum logic [1:0] {
        RA_STAT  = 2'd0,
        RA_LOW   = 2'd1,
        RA_HIGH  = 2'd2,
        RA_UPPER = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_PUSH,
        ACT_OVERRUN,
        ACT_POP,
        ACT_UNDERRUN,
        ACT_RELOCATE,
        ACT_TOP_WR
    } stk_act_e;

    localparam int STAT_FULL_BIT = 5;
    localparam int STAT_UNF_BIT  = 6;
    localparam int STAT_OVF_BIT  = 7;

endpackage

// File: rtl/retstack_mem.sv
module retstack_mem #(
    parameter int ADDR_W = 21,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data
);
    localparam int DEPTH = (1 << PTR_W) - 1;

    logic [ADDR_W-1:0] slot [1:DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 1; i <= DEPTH; i++) begin
                slot[i] <= '0;
            end
        end else if (wr_en && (wr_idx != '0)) begin
            slot[wr_idx] <= wr_data;
        end
    end

    // Index zero has no storage: it reads as zero.
    always_comb begin
        if (rd_idx == '0) begin
            rd_data = '0;
        end else begin
            rd_data = slot[rd_idx];
        end
    end
endmodule

// File: rtl/retstack_ctrl.sv
module retstack_ctrl
    import retstack_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop_req,
    input  logic              ptr_we,
    input  logic [PTR_W-1:0]  ptr_wdata,
    input  logic              ovf_wdata,
    input  logic              unf_wdata,
    input  logic              top_we,
    input  logic [ADDR_W-1:0] top_wdata,
    output logic [PTR_W-1:0]  ptr_q,
    output stk_state_e        state_q,
    output logic              ovf_q,
    output logic              unf_q,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_idx,
    output logic [ADDR_W-1:0] mem_wdata
);
    localparam logic [PTR_W-1:0] PTR_MAX  = '1;
    localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);
    localparam logic [PTR_W-1:0] PTR_PEAK = PTR_MAX - PTR_ONE;

    stk_act_e          act;
    stk_state_e        state_d;
    logic [PTR_W-1:0]  ptr_d;
    logic              ovf_d;
    logic              unf_d;

    function automatic stk_state_e state_for(input logic [PTR_W-1:0] p);
        if (p == '0) begin
            return STK_EMPTY;
        end else if (p == PTR_MAX) begin
            return STK_FULL;
        end
        return STK_PARTIAL;
    endfunction

    // Event selection: push over pop over register writes.
    always_comb begin
        act = ACT_IDLE;
        if (push_req) begin
            act = (state_q == STK_FULL) ? ACT_OVERRUN : ACT_PUSH;
        end else if (pop_req) begin
            act = (state_q == STK_EMPTY) ? ACT_UNDERRUN : ACT_POP;
        end else if (ptr_we) begin
            act = ACT_RELOCATE;
        end else if (top_we && (state_q != STK_EMPTY)) begin
            act = ACT_TOP_WR;
        end
    end

    // Next state, pointer and flags.
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        ovf_d   = ovf_q;
        unf_d   = unf_q;
        unique case (state_q)
            STK_EMPTY: begin
                if (act == ACT_PUSH) begin          // fill
                    ptr_d   = PTR_ONE;
                    state_d = STK_PARTIAL;
                end else if (act == ACT_UNDERRUN) begin  // underrun
                    unf_d = 1'b1;
                end
            end
            STK_PARTIAL: begin
                if (act == ACT_PUSH) begin          // grow
                    ptr_d   = ptr_q + PTR_ONE;
                    state_d = (ptr_q == PTR_PEAK) ? STK_FULL : STK_PARTIAL;
                end else if (act == ACT_POP) begin  // shrink
                    ptr_d   = ptr_q - PTR_ONE;
                    state_d = (ptr_q == PTR_ONE) ? STK_EMPTY : STK_PARTIAL;
                end
            end
            STK_FULL: begin
                if (act == ACT_POP) begin           // drain
                    ptr_d   = ptr_q - PTR_ONE;
                    state_d = STK_PARTIAL;
                end else if (act == ACT_OVERRUN) begin  // overrun
                    ovf_d = 1'b1;
                end
            end
            default: begin
                ptr_d   = '0;
                state_d = STK_EMPTY;
            end
        endcase
        if (act == ACT_RELOCATE) begin              // relocate
            ptr_d   = ptr_wdata;
            ovf_d   = ovf_wdata;
            unf_d   = unf_wdata;
            state_d = state_for(ptr_wdata);
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STK_EMPTY;
            ptr_q   <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            ovf_q   <= ovf_d;
            unf_q   <= unf_d;
        end
    end

    // Outputs to the entry storage.
    always_comb begin
        mem_we    = 1'b0;
        mem_idx   = ptr_q;
        mem_wdata = top_wdata;
        unique case (act)
            ACT_PUSH: begin
                mem_we    = 1'b1;
                mem_idx   = ptr_q + PTR_ONE;
                mem_wdata = push_addr;
            end
            ACT_TOP_WR: begin
                mem_we = 1'b1;
            end
            default: begin
                mem_we = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/retstack_regif.sv
module retstack_regif
    import retstack_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int PTR_W  = 5
) (
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic [PTR_W-1:0]  ptr,
    input  logic              full,
    input  logic              ovf,
    input  logic              unf,
    input  logic [ADDR_W-1:0] top_word,
    output logic [7:0]        reg_rdata,
    output logic              ptr_we,
    output logic [PTR_W-1:0]  ptr_wdata,
    output logic              ovf_wdata,
    output logic              unf_wdata,
    output logic              top_we,
    output logic [ADDR_W-1:0] top_wdata
);
    localparam int UP_W = ADDR_W - 16;

    reg_addr_e sel;

    assign sel       = reg_addr_e'(reg_addr);
    assign ptr_we    = reg_we && (sel == RA_STAT);
    assign top_we    = reg_we && (sel != RA_STAT);
    assign ptr_wdata = reg_wdata[PTR_W-1:0];
    assign ovf_wdata = reg_wdata[STAT_OVF_BIT];
    assign unf_wdata = reg_wdata[STAT_UNF_BIT];

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            RA_STAT: begin
                reg_rdata[PTR_W-1:0]     = ptr;
                reg_rdata[STAT_FULL_BIT] = full;
                reg_rdata[STAT_UNF_BIT]  = unf;
                reg_rdata[STAT_OVF_BIT]  = ovf;
            end
            RA_LOW:   reg_rdata         = top_word[7:0];
            RA_HIGH:  reg_rdata         = top_word[15:8];
            RA_UPPER: reg_rdata[UP_W-1:0] = top_word[ADDR_W-1:16];
            default:  reg_rdata         = '0;
        endcase
    end

    // Merge one byte lane into the current top entry.
    always_comb begin
        top_wdata = top_word;
        unique case (sel)
            RA_LOW:   top_wdata[7:0]         = reg_wdata;
            RA_HIGH:  top_wdata[15:8]        = reg_wdata;
            RA_UPPER: top_wdata[ADDR_W-1:16] = reg_wdata[UP_W-1:0];
            default:  top_wdata              = top_word;
        endcase
    end
endmodule

// File: rtl/retstack.sv
module retstack
    import retstack_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int PTR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic              pop_req,
    output logic [ADDR_W-1:0] pop_addr,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);
    logic [PTR_W-1:0]  ptr_q;
    stk_state_e        state_q;
    logic              ovf_q;
    logic              unf_q;
    logic              full;
    logic              mem_we;
    logic [PTR_W-1:0]  mem_idx;
    logic [ADDR_W-1:0] mem_wdata;
    logic [ADDR_W-1:0] top_word;
    logic              ptr_we;
    logic [PTR_W-1:0]  ptr_wdata;
    logic              ovf_wdata;
    logic              unf_wdata;
    logic              top_we;
    logic [ADDR_W-1:0] top_wdata;

    assign full     = (state_q == STK_FULL);
    assign pop_addr = top_word;

    retstack_ctrl #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .push_addr (push_addr),
        .pop_req   (pop_req),
        .ptr_we    (ptr_we),
        .ptr_wdata (ptr_wdata),
        .ovf_wdata (ovf_wdata),
        .unf_wdata (unf_wdata),
        .top_we    (top_we),
        .top_wdata (top_wdata),
        .ptr_q     (ptr_q),
        .state_q   (state_q),
        .ovf_q     (ovf_q),
        .unf_q     (unf_q),
        .mem_we    (mem_we),
        .mem_idx   (mem_idx),
        .mem_wdata (mem_wdata)
    );

    retstack_mem #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_idx  (mem_idx),
        .wr_data (mem_wdata),
        .rd_idx  (ptr_q),
        .rd_data (top_word)
    );

    retstack_regif #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_regif (
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .ptr       (ptr_q),
        .full      (full),
        .ovf       (ovf_q),
        .unf       (unf_q),
        .top_word  (top_word),
        .reg_rdata (reg_rdata),
        .ptr_we    (ptr_we),
        .ptr_wdata (ptr_wdata),
        .ovf_wdata (ovf_wdata),
        .unf_wdata (unf_wdata),
        .top_we    (top_we),
        .top_wdata (top_wdata)
    );
endmodule

// File: rtl/retstack_checker.sv
module retstack_checker #(
    parameter int ADDR_W = 21,
    parameter int PTR_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_req,
    input logic [ADDR_W-1:0] push_addr,
    input logic              pop_req,
    input logic [ADDR_W-1:0] pop_addr,
    input logic              reg_we,
    input logic [1:0]        reg_addr,
    input logic [7:0]        reg_rdata,
    input logic [PTR_W-1:0]  ptr,
    input logic              ovf,
    input logic              unf
);
    localparam logic [PTR_W-1:0] PMAX = '1;
    localparam logic [PTR_W-1:0] PONE = PTR_W'(1);

    a_r2_push_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && ptr != PMAX) |=> (ptr == $past(ptr) + PONE && pop_addr == $past(push_addr)));

    a_r3_pop_retreats: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && ptr != '0) |=> (ptr == $past(ptr) - PONE));

    a_r4_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == '0) |-> (pop_addr == '0 && (reg_addr == 2'd0 || reg_rdata == 8'd0)));

    a_r5_full_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd0) |-> (reg_rdata[5] == (ptr == PMAX)));

    a_r6_overflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && ptr == PMAX) |=> (ptr == PMAX && ovf && $stable(pop_addr)));

    a_r7_underflow_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !push_req && ptr == '0) |=> (ptr == '0 && unf));

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(reg_we && reg_addr == 2'd0)) |=> ovf);

    a_r8_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (unf && !(reg_we && reg_addr == 2'd0)) |=> unf);

    a_r11_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pop_req && ptr != PMAX) |=> (ptr == $past(ptr) + PONE));
endmodule

bind retstack retstack_checker #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .push_addr (push_addr),
    .pop_req   (pop_req),
    .pop_addr  (pop_addr),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .ptr       (ptr_q),
    .ovf       (ovf_q),
    .unf       (unf_q)
);

// File: tb/retstack_bench.sv
module retstack_bench;
    localparam int AW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_req = 1'b0;
    logic [AW-1:0] push_addr = '0;
    logic          pop_req = 1'b0;
    logic [AW-1:0] pop_addr;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [7:0]    reg_wdata = 8'd0;
    logic [7:0]    reg_rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    retstack u_retstack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .push_addr (push_addr),
        .pop_req   (pop_req),
        .pop_addr  (pop_addr),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    function automatic logic [AW-1:0] pat(input int i);
        return AW'((i * 32'h0A3C5 + 32'h01234) ^ (i << 17));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        tick();
        reg_we    = 1'b0;
    endtask

    task automatic push(input logic [AW-1:0] a);
        push_addr = a;
        push_req  = 1'b1;
        tick();
        push_req  = 1'b0;
    endtask

    task automatic pop(output logic [AW-1:0] got);
        pop_req = 1'b1;
        #1;
        got = pop_addr;
        tick();
        pop_req = 1'b0;
    endtask

    task automatic rd_top(output logic [AW-1:0] w);
        logic [7:0] b0, b1, b2;
        rd(2'd1, b0);
        rd(2'd2, b1);
        rd(2'd3, b2);
        w = {b2[AW-17:0], b1, b0};
        chk("R10 upper pad", {24'd0, b2[7:AW-16]}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]    s;
        logic [AW-1:0] w;
        logic [AW-1:0] g;

        #12;
        rst_n = 1'b1;
        tick();

        // R1: reset state
        rd(2'd0, s);
        chk("R1 status", {24'd0, s}, 32'h00);
        chk("R1 pop_addr", {11'd0, pop_addr}, 32'd0);
        rd_top(w);
        chk("R1 top", {11'd0, w}, 32'd0);

        // R4: top writes ignored while empty
        wr(2'd1, 8'hAA);
        wr(2'd3, 8'h1F);
        rd_top(w);
        chk("R4 empty top", {11'd0, w}, 32'd0);
        rd(2'd0, s);
        chk("R4 ptr stays", {24'd0, s}, 32'h00);

        // R7: underflow
        pop(g);
        chk("R7 pop value", {11'd0, g}, 32'd0);
        rd(2'd0, s);
        chk("R7 status", {24'd0, s}, 32'h40);
        repeat (3) tick();
        rd(2'd0, s);
        chk("R8 unf sticky", {24'd0, s}, 32'h40);
        wr(2'd0, 8'h00);
        rd(2'd0, s);
        chk("R8 unf clear", {24'd0, s}, 32'h00);

        // R2, R5: fill
        for (int i = 1; i <= 31; i++) begin
            push(pat(i));
            chk("R2 pop_addr", {11'd0, pop_addr}, {11'd0, pat(i)});
            rd(2'd0, s);
            chk("R2/R5 status", {24'd0, s}, (i == 31) ? 32'h20 | i : i);
            rd_top(w);
            chk("R2 top regs", {11'd0, w}, {11'd0, pat(i)});
        end

        // R6: overflow
        push(21'h1ABCDE);
        rd(2'd0, s);
        chk("R6 status", {24'd0, s}, 32'hBF);
        chk("R6 entry kept", {11'd0, pop_addr}, {11'd0, pat(31)});
        repeat (4) tick();
        rd(2'd0, s);
        chk("R8 ovf sticky", {24'd0, s}, 32'hBF);
        wr(2'd0, 8'd31);
        rd(2'd0, s);
        chk("R8/R9 ovf clear", {24'd0, s}, 32'h3F);

        // R3, R12: drain in reverse order
        for (int i = 31; i >= 1; i--) begin
            pop(g);
            chk("R12 lifo", {11'd0, g}, {11'd0, pat(i)});
            rd(2'd0, s);
            chk("R3 ptr", {24'd0, s}, i - 1);
        end

        // R9, R5: pointer sweep
        for (int p = 0; p <= 31; p++) begin
            wr(2'd0, 8'(p));
            rd(2'd0, s);
            chk("R9 ptr sweep", {24'd0, s}, (p == 31) ? 32'h20 | p : p);
            chk("R9 top at ptr", {11'd0, pop_addr}, (p == 0) ? 32'd0 : {11'd0, pat(p)});
        end
        wr(2'd0, 8'hC3);
        rd(2'd0, s);
        chk("R9 flag write", {24'd0, s}, 32'hC3);
        wr(2'd0, 8'h05);

        // R10: byte lanes
        wr(2'd1, 8'h11);
        rd_top(w);
        chk("R10 low", {11'd0, w}, {11'd0, pat(5)[AW-1:8], 8'h11});
        wr(2'd2, 8'h22);
        rd_top(w);
        chk("R10 high", {11'd0, w}, {11'd0, pat(5)[AW-1:16], 16'h2211});
        wr(2'd3, 8'hFF);
        rd_top(w);
        chk("R10 upper", {11'd0, w}, 32'h1F2211);
        chk("R10 pop_addr", {11'd0, pop_addr}, 32'h1F2211);

        // R11: push wins over pop; events drop register writes
        push_addr = 21'h0F0F0;
        push_req  = 1'b1;
        pop_req   = 1'b1;
        tick();
        push_req  = 1'b0;
        pop_req   = 1'b0;
        rd(2'd0, s);
        chk("R11 push over pop", {24'd0, s}, 32'd6);
        chk("R11 pushed value", {11'd0, pop_addr}, 32'h0F0F0);
        reg_addr  = 2'd0;
        reg_wdata = 8'h00;
        reg_we    = 1'b1;
        push_addr = 21'h12345;
        push_req  = 1'b1;
        tick();
        reg_we    = 1'b0;
        push_req  = 1'b0;
        rd(2'd0, s);
        chk("R11 write dropped", {24'd0, s}, 32'd7);
        chk("R11 push done", {11'd0, pop_addr}, 32'h12345);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule